// File: doc/BRIEF.md
# Eight-Bit Timer with Buffered Compare Channel

This block is an 8-bit timer/counter with a single compare channel. A tick-enable input stands in for the prescaled timer clock: the counter advances only on cycles where it is high. A waveform mode chooses how the counter sequences. An equality comparator checks the count against an active threshold on each tick. A hit raises a compare flag one tick later and drives the wave output through a waveform generator.

In the two PWM modes, CPU writes to the threshold are held in a shadow register. The shadow is copied into the active threshold at a fixed point of the count sequence, so no period is cut short or stretched. In the other two modes, writes take effect at once.

Software reaches the block through a small register port with a 2-bit address. Writes take one cycle and reads are combinational. Clearing the flags uses the usual write-one convention, and each flag also has an acknowledge input.

Top module: `tmr8_cmp_top`

## Requirements
- R1: The counter moves only on tick cycles. The mode field at CTRL[1:0] selects the sequence. 2'b00 counts 0..255 and wraps. 2'b11 does the same. 2'b10 returns to 0 on the tick where the count equals the active threshold. 2'b01 counts up to 255, then down to 0, then up again. Reset gives count 0, counting up.
- R2: On a tick where the count equals the active threshold, the match is recorded. The compare flag (FLAGS bit 0, address 3) becomes 1 only after the following tick.
- R3: Writing a 1 to FLAGS bit 0 clears the compare flag, and so does a one-cycle pulse on `cmp_ack`. Writing a 0 to that bit leaves the flag unchanged.
- R4: `cmp_irq` is the compare flag gated by CTRL bit 4. `ovf_irq` is the overflow flag (FLAGS bit 1) gated by CTRL bit 5.
- R5: In modes 2'b11 and 2'b01, a write to address 2 loads only the shadow register. The shadow moves into the active threshold on the tick that leaves count 255 in mode 2'b11, and on the tick that leaves the bottom (count 0 while counting down) in mode 2'b01. A read of address 2 in these modes returns the shadow.
- R6: In modes 2'b00 and 2'b10, a write to address 2 updates the active threshold in the same cycle.
- R7: The overflow flag is set on the tick that leaves count 255 in modes 2'b00, 2'b10 and 2'b11. In mode 2'b01 it is set on the bottom tick. Writing 1 to FLAGS bit 1, or pulsing `ovf_ack`, clears it.
- R8: In mode 2'b11, output action CTRL[3:2]=2'b10 drives the output high on the wrap and low on a match. A match at 255 loses to the wrap. Over one 256-tick period, the output is high for k+1 ticks for threshold k. Action 2'b11 inverts this.
- R9: In mode 2'b01 with action 2'b10, a match while counting up drives the output low, and a match while counting down drives it high. For threshold k in 1..254, the output is high for 2k of the 510 ticks of each period.
- R10: In modes 2'b00 and 2'b10, a match applies the action: 2'b01 toggles the output, 2'b10 clears it, and 2'b11 sets it. In mode 2'b10 with toggle, the output period is 2(k+1) ticks and the output is high for k+1 of them.
- R11: A one-cycle pulse on `force_cmp` applies the output action once in modes 2'b00 and 2'b10, and it never sets the compare flag. In PWM modes the pulse is ignored.
- R12: With action 2'b00 the output pin is held low and the internal output level is frozen. Restoring an action makes the preserved level visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick enable (prescaled clock stand-in) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 COUNT, 2 threshold, 3 FLAGS |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational register read data |
| cmp_ack | input | 1 | Compare flag acknowledge |
| ovf_ack | input | 1 | Overflow flag acknowledge |
| force_cmp | input | 1 | Force-compare strobe |
| wave_out | output | 1 | Waveform output |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover:
- the count holding between ticks,
- the turnaround and clear-on-compare restart of the counter,
- the compare flag staying low on the tick of a first match,
- flag clears,
- direct threshold writes in the non-PWM modes,
- the active threshold holding between ticks in the PWM modes,
- force strobes being ignored in PWM modes.

Other properties only show up over whole count periods, so the bench scenarios have to cover them. These are the duty cycles for each threshold in both PWM modes, the toggle period in clear-on-compare mode, and when a shadowed write actually takes effect. The exact tick at which the overflow flag rises, and interrupt gating, are also left to the bench.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_PHASE  = 2'b01,
        WM_CTC    = 2'b10,
        WM_FAST   = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        OA_OFF    = 2'b00,
        OA_TOGGLE = 2'b01,
        OA_CLEAR  = 2'b10,
        OA_SET    = 2'b11
    } oact_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_CMP   = 2'd2;
    localparam logic [1:0] A_FLAGS = 2'd3;

    function automatic logic is_pwm(wmode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  wmode_e           mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             up_o,
    output logic             at_max_o,
    output logic             bottom_evt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             up;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            case (mode_i)
                WM_PHASE: begin
                    if (st_q.up) begin
                        if (st_q.count == CNT_MAX) begin
                            st_d.up    = 1'b0;
                            st_d.count = st_q.count - CNT_ONE;
                        end else begin
                            st_d.count = st_q.count + CNT_ONE;
                        end
                    end else begin
                        if (st_q.count == '0) begin
                            st_d.up    = 1'b1;
                            st_d.count = st_q.count + CNT_ONE;
                        end else begin
                            st_d.count = st_q.count - CNT_ONE;
                        end
                    end
                end
                WM_CTC: begin
                    st_d.up    = 1'b1;
                    st_d.count = (st_q.count == cmp_i) ? '0 : st_q.count + CNT_ONE;
                end
                default: begin
                    st_d.up    = 1'b1;
                    st_d.count = st_q.count + CNT_ONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, up: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o      = st_q.count;
    assign up_o         = st_q.up;
    assign at_max_o     = (st_q.count == CNT_MAX);
    assign bottom_evt_o = tick_i && (mode_i == WM_PHASE) && !st_q.up && (st_q.count == '0);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.count));

    p_phase_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i == WM_PHASE && st_q.up && st_q.count == CNT_MAX)
        |=> (st_q.count == CNT_MAX - CNT_ONE && !st_q.up));

    p_ctc_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i == WM_CTC && st_q.count == cmp_i) |=> (st_q.count == '0));

endmodule

// File: rtl/tmr8_cmp_unit.sv
module tmr8_cmp_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  wmode_e           mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             at_max_i,
    input  logic             bottom_evt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             w1c_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] active_o,
    output logic [CNT_W-1:0] shadow_o,
    output logic             match_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
        logic             pend;
        logic             flag;
    } cmp_st_t;

    cmp_st_t st_q, st_d;
    logic    pwm;
    logic    commit;

    always_comb begin
        pwm     = is_pwm(mode_i);
        match_o = (count_i == st_q.active);
        commit  = ((mode_i == WM_FAST) && tick_i && at_max_i)
                || ((mode_i == WM_PHASE) && bottom_evt_i);

        st_d = st_q;
        if (commit) begin
            st_d.active = st_q.shadow;
        end
        if (wr_i) begin
            st_d.shadow = wdata_i;
            if (!pwm) begin
                st_d.active = wdata_i;
            end
        end
        if (tick_i) begin
            st_d.pend = match_o;
        end
        if (w1c_i || ack_i) begin
            st_d.flag = 1'b0;
        end
        if (tick_i && st_q.pend) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign shadow_o = st_q.shadow;
    assign flag_o   = st_q.flag;

    p_flag_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && match_o && !st_q.pend && !st_q.flag) |=> !st_q.flag);

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((w1c_i || ack_i) && !(tick_i && st_q.pend)) |=> !st_q.flag);

    p_direct_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !is_pwm(mode_i)) |=> (st_q.active == $past(wdata_i)));

    p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(mode_i) && !tick_i) |=> $stable(st_q.active));

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
    import tmr8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  wmode_e mode_i,
    input  oact_e  com_i,
    input  logic   match_i,
    input  logic   at_max_i,
    input  logic   up_i,
    input  logic   force_i,
    output logic   wave_o
);
    typedef struct packed {
        logic wave;
    } wg_st_t;

    wg_st_t st_q, st_d;

    function automatic logic apply_act(oact_e a, logic cur);
        case (a)
            OA_TOGGLE: return !cur;
            OA_CLEAR:  return 1'b0;
            OA_SET:    return 1'b1;
            default:   return cur;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        case (mode_i)
            WM_FAST: begin
                if (tick_i) begin
                    if (at_max_i) begin
                        if (com_i == OA_CLEAR)    st_d.wave = 1'b1;
                        else if (com_i == OA_SET) st_d.wave = 1'b0;
                    end else if (match_i) begin
                        if (com_i == OA_CLEAR)    st_d.wave = 1'b0;
                        else if (com_i == OA_SET) st_d.wave = 1'b1;
                    end
                end
            end
            WM_PHASE: begin
                if (tick_i && match_i) begin
                    if (com_i == OA_CLEAR)    st_d.wave = !up_i;
                    else if (com_i == OA_SET) st_d.wave = up_i;
                end
            end
            default: begin
                if ((tick_i && match_i) || force_i) begin
                    st_d.wave = apply_act(com_i, st_q.wave);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = (com_i == OA_OFF) ? 1'b0 : st_q.wave;

    p_force_pwm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && is_pwm(mode_i) && !tick_i) |=> $stable(st_q.wave));

    p_off_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i == OA_OFF) |=> $stable(st_q.wave));

endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ovf_evt_i,
    input  logic              ovf_ack_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic [DATA_W-1:0] cmp_rd_i,
    input  logic              cmp_flag_i,
    output wmode_e            mode_o,
    output oact_e             com_o,
    output logic              cmp_ie_o,
    output logic              ovf_ie_o,
    output logic              cmp_wr_o,
    output logic              cmp_w1c_o,
    output logic              ovf_flag_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int MODE_LSB = 0;
    localparam int COM_LSB  = 2;
    localparam int CIE_BIT  = 4;
    localparam int OIE_BIT  = 5;
    localparam int FL_CMP   = 0;
    localparam int FL_OVF   = 1;

    typedef struct packed {
        wmode_e mode;
        oact_e  com;
        logic   cie;
        logic   oie;
        logic   ovf;
    } reg_st_t;

    reg_st_t st_q, st_d;
    logic    wr_ctrl, wr_flags;
    logic    unused_wbits;

    assign unused_wbits = ^wdata_i[DATA_W-1:OIE_BIT+1];

    always_comb begin
        wr_ctrl  = wr_i && (addr_i == A_CTRL);
        wr_flags = wr_i && (addr_i == A_FLAGS);
        st_d     = st_q;
        if (wr_ctrl) begin
            st_d.mode = wmode_e'(wdata_i[MODE_LSB +: 2]);
            st_d.com  = oact_e'(wdata_i[COM_LSB +: 2]);
            st_d.cie  = wdata_i[CIE_BIT];
            st_d.oie  = wdata_i[OIE_BIT];
        end
        if ((wr_flags && wdata_i[FL_OVF]) || ovf_ack_i) begin
            st_d.ovf = 1'b0;
        end
        if (ovf_evt_i) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: WM_NORMAL, com: OA_OFF, cie: 1'b0, oie: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[MODE_LSB +: 2] = st_q.mode;
                rdata_o[COM_LSB +: 2]  = st_q.com;
                rdata_o[CIE_BIT]       = st_q.cie;
                rdata_o[OIE_BIT]       = st_q.oie;
            end
            A_COUNT: rdata_o = count_i;
            A_CMP:   rdata_o = cmp_rd_i;
            default: begin
                rdata_o[FL_CMP] = cmp_flag_i;
                rdata_o[FL_OVF] = st_q.ovf;
            end
        endcase
    end

    assign mode_o     = st_q.mode;
    assign com_o      = st_q.com;
    assign cmp_ie_o   = st_q.cie;
    assign ovf_ie_o   = st_q.oie;
    assign ovf_flag_o = st_q.ovf;
    assign cmp_wr_o   = wr_i && (addr_i == A_CMP);
    assign cmp_w1c_o  = wr_flags && wdata_i[FL_CMP];

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack_i && !ovf_evt_i) |=> !st_q.ovf);

endmodule

// File: rtl/tmr8_cmp_top.sv
module tmr8_cmp_top
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             cmp_ack,
    input  logic             ovf_ack,
    input  logic             force_cmp,
    output logic             wave_out,
    output logic             cmp_irq,
    output logic             ovf_irq
);
    localparam int DATA_W = CNT_W;

    wmode_e           mode;
    oact_e            com;
    logic             cmp_ie, ovf_ie, cmp_wr, cmp_w1c, ovf_flag, ovf_evt;
    logic [CNT_W-1:0] count, active, shadow, cmp_rd;
    logic             up, at_max, bottom_evt, match, cmp_flag;

    tmr8_counter #(.CNT_W(CNT_W)) i_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_en),
        .mode_i       (mode),
        .cmp_i        (active),
        .count_o      (count),
        .up_o         (up),
        .at_max_o     (at_max),
        .bottom_evt_o (bottom_evt)
    );

    tmr8_cmp_unit #(.CNT_W(CNT_W)) i_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_en),
        .mode_i       (mode),
        .count_i      (count),
        .at_max_i     (at_max),
        .bottom_evt_i (bottom_evt),
        .wr_i         (cmp_wr),
        .wdata_i      (bus_wdata),
        .w1c_i        (cmp_w1c),
        .ack_i        (cmp_ack),
        .active_o     (active),
        .shadow_o     (shadow),
        .match_o      (match),
        .flag_o       (cmp_flag)
    );

    tmr8_wavegen i_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_en),
        .mode_i   (mode),
        .com_i    (com),
        .match_i  (match),
        .at_max_i (at_max),
        .up_i     (up),
        .force_i  (force_cmp),
        .wave_o   (wave_out)
    );

    assign ovf_evt = (mode == WM_PHASE) ? bottom_evt : (tick_en && at_max);
    assign cmp_rd  = is_pwm(mode) ? shadow : active;

    tmr8_regs #(.DATA_W(DATA_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .ovf_evt_i  (ovf_evt),
        .ovf_ack_i  (ovf_ack),
        .count_i    (count),
        .cmp_rd_i   (cmp_rd),
        .cmp_flag_i (cmp_flag),
        .mode_o     (mode),
        .com_o      (com),
        .cmp_ie_o   (cmp_ie),
        .ovf_ie_o   (ovf_ie),
        .cmp_wr_o   (cmp_wr),
        .cmp_w1c_o  (cmp_w1c),
        .ovf_flag_o (ovf_flag),
        .rdata_o    (bus_rdata)
    );

    assign cmp_irq = cmp_flag && cmp_ie;
    assign ovf_irq = ovf_flag && ovf_ie;

endmodule

// File: tb/test_tmr8_cmp_top.sv
`timescale 1ns/1ps
module test_tmr8_cmp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_ack = 1'b0;
    logic       ovf_ack = 1'b0;
    logic       force_cmp = 1'b0;
    logic       wave_out, cmp_irq, ovf_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr8_cmp_top i_tmr8_cmp_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_ack(cmp_ack), .ovf_ack(ovf_ack), .force_cmp(force_cmp),
        .wave_out(wave_out), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; cmp_ack = 1'b0;
        ovf_ack = 1'b0; force_cmp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic step(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic pulse_force();
        @(negedge clk); force_cmp = 1'b1;
        @(negedge clk); force_cmp = 1'b0;
    endtask

    task automatic run_meas(input int n, output int hi, output int mx);
        @(negedge clk);
        bus_addr = 2'd1;
        tick_en = 1'b1;
        hi = 0; mx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi += int'(wave_out);
            if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, hi, mx;
        int fast_k[8] = '{0, 1, 2, 63, 128, 200, 254, 255};
        int pc_k[5]   = '{1, 2, 77, 128, 254};
        int ctc_k[5]  = '{0, 1, 5, 40, 99};

        // Reset state (R1)
        do_reset();
        rd(2'd0, v); chk("R1 reset ctrl", v, 0);
        rd(2'd1, v); chk("R1 reset count", v, 0);
        rd(2'd3, v); chk("R3 reset flags", v, 0);
        chk("R12 reset wave", int'(wave_out), 0);
        chk("R4 reset irqs", int'(cmp_irq) + int'(ovf_irq), 0);

        // Flag lag, clears, irq gating (R2 R3 R4)
        do_reset();
        wr(2'd2, 8'd10);
        step(10);
        rd(2'd1, v); chk("R1 count after 10 ticks", v, 10);
        step(1);
        rd(2'd3, v); chk("R2 flag not on match tick", v & 1, 0);
        step(1);
        rd(2'd3, v); chk("R2 flag one tick after match", v & 1, 1);
        chk("R4 irq masked", int'(cmp_irq), 0);
        wr(2'd0, 8'h10);
        @(negedge clk); chk("R4 irq enabled", int'(cmp_irq), 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R3 write zero keeps flag", v & 1, 1);
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R3 write one clears flag", v & 1, 0);
        chk("R4 irq follows flag", int'(cmp_irq), 0);
        step(254);
        step(2);
        rd(2'd3, v); chk("R2 flag again after wrap", v & 1, 1);
        @(negedge clk); cmp_ack = 1'b1;
        @(negedge clk); cmp_ack = 1'b0;
        rd(2'd3, v); chk("R3 ack clears flag", v & 1, 0);

        // Overflow normal mode (R7 R4)
        do_reset();
        step(255);
        rd(2'd3, v); chk("R7 no ovf before wrap", (v >> 1) & 1, 0);
        step(1);
        rd(2'd3, v); chk("R7 ovf on wrap", (v >> 1) & 1, 1);
        chk("R4 ovf irq masked", int'(ovf_irq), 0);
        wr(2'd0, 8'h20);
        @(negedge clk); chk("R4 ovf irq enabled", int'(ovf_irq), 1);
        @(negedge clk); ovf_ack = 1'b1;
        @(negedge clk); ovf_ack = 1'b0;
        rd(2'd3, v); chk("R7 ovf ack clears", (v >> 1) & 1, 0);

        // Overflow phase-correct mode (R7)
        do_reset();
        wr(2'd0, 8'h01);
        step(510);
        rd(2'd3, v); chk("R7 pc no ovf before bottom", (v >> 1) & 1, 0);
        rd(2'd1, v); chk("R1 pc back at zero", v, 0);
        step(1);
        rd(2'd3, v); chk("R7 pc ovf at bottom", (v >> 1) & 1, 1);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R7 ovf write-one clear", (v >> 1) & 1, 0);

        // Buffering in fast PWM (R5)
        do_reset();
        wr(2'd2, 8'd100);
        wr(2'd0, 8'h03);
        step(20);
        wr(2'd2, 8'd30);
        rd(2'd2, v); chk("R5 read returns shadow", v, 30);
        step(20);
        rd(2'd3, v); chk("R5 fast write not active yet", v & 1, 0);
        step(62);
        rd(2'd3, v); chk("R5 fast old threshold still active", v & 1, 1);
        wr(2'd3, 8'h03);
        step(154);
        rd(2'd1, v); chk("R1 fast wrapped", v, 0);
        step(32);
        rd(2'd3, v); chk("R5 fast commit at top", v & 1, 1);

        // Direct write in normal mode (R6)
        do_reset();
        wr(2'd2, 8'd100);
        step(20);
        wr(2'd2, 8'd30);
        step(20);
        rd(2'd3, v); chk("R6 normal write immediate", v & 1, 1);

        // Buffering in phase-correct (R5)
        do_reset();
        wr(2'd2, 8'd100);
        wr(2'd0, 8'h01);
        step(20);
        wr(2'd2, 8'd30);
        step(20);
        rd(2'd3, v); chk("R5 pc write not active yet", v & 1, 0);
        step(470);
        rd(2'd1, v); chk("R1 pc reached bottom", v, 0);
        wr(2'd3, 8'h03);
        step(1);
        step(31);
        rd(2'd3, v); chk("R5 pc commit at bottom", v & 1, 1);

        // Fast PWM duty sweep (R8)
        foreach (fast_k[i]) begin
            do_reset();
            wr(2'd2, 8'(fast_k[i]));
            wr(2'd0, 8'h0B);
            run_meas(256, hi, mx);
            run_meas(256, hi, mx);
            chk($sformatf("R8 fast high k=%0d", fast_k[i]), hi, fast_k[i] + 1);
            chk("R1 fast max count", mx, 255);
        end
        do_reset();
        wr(2'd2, 8'd50);
        wr(2'd0, 8'h0F);
        run_meas(256, hi, mx);
        run_meas(256, hi, mx);
        chk("R8 fast inverted k=50", hi, 205);

        // Phase-correct duty sweep (R9)
        foreach (pc_k[i]) begin
            do_reset();
            wr(2'd2, 8'(pc_k[i]));
            wr(2'd0, 8'h09);
            run_meas(510, hi, mx);
            run_meas(510, hi, mx);
            chk($sformatf("R9 pc high k=%0d", pc_k[i]), hi, 2 * pc_k[i]);
            chk("R1 pc max count", mx, 255);
        end

        // Clear-on-compare toggle sweep (R10 R1)
        foreach (ctc_k[i]) begin
            do_reset();
            wr(2'd2, 8'(ctc_k[i]));
            wr(2'd0, 8'h06);
            run_meas(4 * (ctc_k[i] + 1), hi, mx);
            run_meas(2 * (ctc_k[i] + 1), hi, mx);
            chk($sformatf("R10 ctc toggle high k=%0d", ctc_k[i]), hi, ctc_k[i] + 1);
            chk($sformatf("R1 ctc max k=%0d", ctc_k[i]), mx, ctc_k[i]);
        end

        // Set and clear on match in clear-on-compare (R10)
        do_reset();
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h0E);
        step(5);
        chk("R10 set not before match", int'(wave_out), 0);
        step(1);
        chk("R10 set on match", int'(wave_out), 1);
        wr(2'd0, 8'h0A);
        step(6);
        chk("R10 clear on match", int'(wave_out), 0);

        // Force strobe (R11) and disconnected output (R12)
        do_reset();
        wr(2'd0, 8'h04);
        pulse_force();
        chk("R11 force toggles", int'(wave_out), 1);
        rd(2'd3, v); chk("R11 force sets no flag", v & 1, 0);
        wr(2'd0, 8'h0B);
        pulse_force();
        chk("R11 force ignored in pwm", int'(wave_out), 1);
        wr(2'd0, 8'h00);
        @(negedge clk); chk("R12 off drives low", int'(wave_out), 0);
        pulse_force();
        wr(2'd0, 8'h04);
        @(negedge clk); chk("R12 level preserved", int'(wave_out), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule